// File: doc/BRIEF.md
# Fine-Grained Multithreaded Fetch Scheduler

This block decides, cycle by cycle, which of many hardware thread contexts may fetch into a single-issue pipeline. The pipeline is 22 stages deep and takes one instruction per cycle. Each context has its own state. A context that is free to run can be chosen. A context that has fetched a branch waits until the branch outcome is delivered back to fetch. A context that missed in the data cache is held for a fixed stall time. If every miss slot is taken when the miss arrives, the context first waits for a slot.

The pipeline reports its events with a context number attached: branch fetched, branch target delivered, load hit and load miss. Loads reach the data cache in stage 20, and a hit costs the thread nothing. Misses share a pool of 16 outstanding-miss slots. Each slot is held for exactly 100 cycles. Among the eligible contexts, the block picks round-robin, starting just after the context chosen last. When no context is eligible, it issues a bubble and adds one to a running bubble count.

Top module: `mt_fetch_sched`

## Requirements
- R1: After reset all 200 contexts are eligible, the first pick is context 0 and the bubble count is 0.
- R2: Each cycle the pick is the lowest-numbered eligible context above the last picked one, wrapping to the lowest eligible context; a bubble leaves the last-picked pointer unchanged.
- R3: A branch-fetch event for a context in cycle T makes it ineligible from cycle T+1. It becomes eligible again in the cycle after its branch-resolve event.
- R4: A miss event in cycle T, when a slot is free, makes the context ineligible for exactly 100 cycles (T+1 through T+100). The context is eligible again in cycle T+101, and its slot is free for reuse from that cycle.
- R5: At most 16 misses hold a slot at once. A miss that finds no free slot puts its context in a waiting state, and the context stays ineligible while it waits.
- R6: At most one slot is allocated per cycle. Waiting contexts take precedence over a new miss, lowest context number first. The 100-cycle stall of a waiting context counts from the cycle of its allocation, not from its miss.
- R7: A load-hit event changes no context's eligibility: the pick sequence is the same as with no hit.
- R8: fetch_valid is low exactly in the cycles with no eligible context. bubble_count rises by one after each such cycle and holds otherwise.
- R9: fetch_ctx is the binary number (0 to 199) of the picked context and is meaningful only while fetch_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| br_fetch_valid | input | 1 | A context fetched a branch this cycle |
| br_fetch_ctx | input | 8 | Context of the fetched branch |
| br_resolve_valid | input | 1 | A branch target is delivered to fetch this cycle |
| br_resolve_ctx | input | 8 | Context whose branch was resolved |
| load_hit_valid | input | 1 | A load of some context hit the data cache |
| load_hit_ctx | input | 8 | Context of the hitting load |
| load_miss_valid | input | 1 | A load of some context missed the data cache |
| load_miss_ctx | input | 8 | Context of the missing load |
| fetch_valid | output | 1 | A context is picked this cycle (low means bubble) |
| fetch_ctx | output | 8 | Picked context number |
| bubble_count | output | 32 | Number of bubble cycles since reset, wrapping |

## Verification
The assertions take for granted that events are consistent with context state. A branch fetch or a miss names a context that is currently eligible, a resolve names a context that is waiting on a branch, and one cycle never carries two events for the same context. The stimulus draws every event from a bench model of the context states, so it keeps within these rules. It issues branch fetches only for the context picked in that cycle. It picks the miss context among eligible contexts other than that one, and the resolve context among branch-waiting contexts. Load hits are aimed at any context at all.

// File: rtl/mt_sched_pkg.sv
package mt_sched_pkg;

    localparam int unsigned DEF_NUM_CTX    = 200;
    localparam int unsigned DEF_MISS_SLOTS = 16;
    localparam int unsigned DEF_MISS_STALL = 100;
    localparam int unsigned DEF_BUBBLE_W   = 32;

    // Per-context scheduling state
    typedef enum logic [1:0] {
        CTX_RUN     = 2'd0,  // eligible to fetch
        CTX_BRANCH  = 2'd1,  // waiting for branch target
        CTX_WAITSLT = 2'd2,  // missed, waiting for a free miss slot
        CTX_STALL   = 2'd3   // holding a miss slot, stall timer running
    } ctx_state_e;

    // Index width that never collapses to zero bits
    function automatic int unsigned idx_width(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/ctx_state_table.sv
module ctx_state_table
    import mt_sched_pkg::*;
#(
    parameter int unsigned NUM_CTX = DEF_NUM_CTX,
    localparam int unsigned CTX_W  = idx_width(NUM_CTX)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               br_fetch_v,
    input  logic [CTX_W-1:0]   br_fetch_id,
    input  logic               br_res_v,
    input  logic [CTX_W-1:0]   br_res_id,
    input  logic               hit_v,
    input  logic [CTX_W-1:0]   hit_id,
    input  logic               miss_v,
    input  logic [CTX_W-1:0]   miss_id,
    input  logic               alloc_v,
    input  logic [CTX_W-1:0]   alloc_id,
    input  logic               rel_v,
    input  logic [CTX_W-1:0]   rel_id,
    output logic [NUM_CTX-1:0] eligible,
    output logic [NUM_CTX-1:0] waiting
);

    for (genvar g = 0; g < NUM_CTX; g++) begin : g_ctx
        localparam logic [CTX_W-1:0] MY_ID = CTX_W'(g);
        ctx_state_e st_q, st_d;

        always_comb begin
            st_d = st_q;
            if (rel_v && rel_id == MY_ID && st_q == CTX_STALL) begin
                st_d = CTX_RUN;
            end else if (alloc_v && alloc_id == MY_ID) begin
                st_d = CTX_STALL;
            end else if (miss_v && miss_id == MY_ID) begin
                st_d = CTX_WAITSLT;
            end else if (br_res_v && br_res_id == MY_ID && st_q == CTX_BRANCH) begin
                st_d = CTX_RUN;
            end else if (br_fetch_v && br_fetch_id == MY_ID) begin
                st_d = CTX_BRANCH;
            end else if (hit_v && hit_id == MY_ID) begin
                st_d = st_q;   // a hit never stalls the thread
            end
        end

        always_ff @(posedge clk) begin
            if (rst) st_q <= CTX_RUN;
            else     st_q <= st_d;
        end

        assign eligible[g] = (st_q == CTX_RUN);
        assign waiting[g]  = (st_q == CTX_WAITSLT);
    end

endmodule

// File: rtl/miss_slot_pool.sv
module miss_slot_pool
    import mt_sched_pkg::*;
#(
    parameter int unsigned NUM_CTX    = DEF_NUM_CTX,
    parameter int unsigned MISS_SLOTS = DEF_MISS_SLOTS,
    parameter int unsigned MISS_STALL = DEF_MISS_STALL,
    localparam int unsigned CTX_W     = idx_width(NUM_CTX),
    localparam int unsigned SLOT_W    = idx_width(MISS_SLOTS),
    localparam int unsigned TMR_W     = $clog2(MISS_STALL + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               miss_v,
    input  logic [CTX_W-1:0]   miss_id,
    input  logic [NUM_CTX-1:0] waiting,
    output logic               alloc_v,
    output logic [CTX_W-1:0]   alloc_id,
    output logic               rel_v,
    output logic [CTX_W-1:0]   rel_id
);

    logic [MISS_SLOTS-1:0] busy_q;
    logic [CTX_W-1:0]      owner_q [MISS_SLOTS];
    logic [TMR_W-1:0]      left_q  [MISS_SLOTS];

    logic              free_v;
    logic [SLOT_W-1:0] free_idx;
    logic              wait_v;
    logic [CTX_W-1:0]  wait_id;

    // Lowest free slot
    always_comb begin
        free_v   = 1'b0;
        free_idx = '0;
        for (int s = MISS_SLOTS - 1; s >= 0; s--) begin
            if (!busy_q[s]) begin
                free_v   = 1'b1;
                free_idx = SLOT_W'(s);
            end
        end
    end

    // Lowest-numbered waiting context
    always_comb begin
        wait_v  = 1'b0;
        wait_id = '0;
        for (int c = NUM_CTX - 1; c >= 0; c--) begin
            if (waiting[c]) begin
                wait_v  = 1'b1;
                wait_id = CTX_W'(c);
            end
        end
    end

    // One allocation per cycle, waiting contexts first
    assign alloc_v  = free_v && (wait_v || miss_v);
    assign alloc_id = wait_v ? wait_id : miss_id;

    // Slot in its last stall cycle (allocation is serial, so at most one)
    always_comb begin
        rel_v  = 1'b0;
        rel_id = '0;
        for (int s = 0; s < MISS_SLOTS; s++) begin
            if (busy_q[s] && left_q[s] == TMR_W'(1)) begin
                rel_v  = 1'b1;
                rel_id = owner_q[s];
            end
        end
    end

    for (genvar s = 0; s < MISS_SLOTS; s++) begin : g_slot
        logic take;
        assign take = alloc_v && (free_idx == SLOT_W'(s));

        always_ff @(posedge clk) begin
            if (rst) begin
                busy_q[s]  <= 1'b0;
                owner_q[s] <= '0;
                left_q[s]  <= '0;
            end else if (take) begin
                busy_q[s]  <= 1'b1;
                owner_q[s] <= alloc_id;
                left_q[s]  <= TMR_W'(MISS_STALL);
            end else if (busy_q[s]) begin
                if (left_q[s] == TMR_W'(1)) begin
                    busy_q[s] <= 1'b0;
                    left_q[s] <= '0;
                end else begin
                    left_q[s] <= left_q[s] - TMR_W'(1);
                end
            end
        end
    end

endmodule

// File: rtl/rr_ctx_picker.sv
module rr_ctx_picker
    import mt_sched_pkg::*;
#(
    parameter int unsigned NUM_CTX = DEF_NUM_CTX,
    localparam int unsigned CTX_W  = idx_width(NUM_CTX)
) (
    input  logic [NUM_CTX-1:0] eligible,
    input  logic [CTX_W-1:0]   last_id,
    output logic               pick_v,
    output logic [CTX_W-1:0]   pick_id
);

    logic             hi_v, lo_v;
    logic [CTX_W-1:0] hi_id, lo_id;

    always_comb begin
        hi_v  = 1'b0;
        lo_v  = 1'b0;
        hi_id = '0;
        lo_id = '0;
        for (int i = NUM_CTX - 1; i >= 0; i--) begin
            if (eligible[i]) begin
                lo_v  = 1'b1;
                lo_id = CTX_W'(i);
                if (CTX_W'(i) > last_id) begin
                    hi_v  = 1'b1;
                    hi_id = CTX_W'(i);
                end
            end
        end
        pick_v  = lo_v;
        pick_id = hi_v ? hi_id : lo_id;
    end

endmodule

// File: rtl/mt_fetch_sched.sv
module mt_fetch_sched
    import mt_sched_pkg::*;
#(
    parameter int unsigned NUM_CTX    = DEF_NUM_CTX,
    parameter int unsigned MISS_SLOTS = DEF_MISS_SLOTS,
    parameter int unsigned MISS_STALL = DEF_MISS_STALL,
    parameter int unsigned BUBBLE_W   = DEF_BUBBLE_W,
    localparam int unsigned CTX_W     = idx_width(NUM_CTX)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                br_fetch_valid,
    input  logic [CTX_W-1:0]    br_fetch_ctx,
    input  logic                br_resolve_valid,
    input  logic [CTX_W-1:0]    br_resolve_ctx,
    input  logic                load_hit_valid,
    input  logic [CTX_W-1:0]    load_hit_ctx,
    input  logic                load_miss_valid,
    input  logic [CTX_W-1:0]    load_miss_ctx,
    output logic                fetch_valid,
    output logic [CTX_W-1:0]    fetch_ctx,
    output logic [BUBBLE_W-1:0] bubble_count
);

    logic [NUM_CTX-1:0] eligible;
    logic [NUM_CTX-1:0] waiting;
    logic               alloc_v, rel_v;
    logic [CTX_W-1:0]   alloc_id, rel_id;
    logic [CTX_W-1:0]   last_q;

    ctx_state_table #(.NUM_CTX(NUM_CTX)) u_table (
        .clk        (clk),
        .rst        (rst),
        .br_fetch_v (br_fetch_valid),
        .br_fetch_id(br_fetch_ctx),
        .br_res_v   (br_resolve_valid),
        .br_res_id  (br_resolve_ctx),
        .hit_v      (load_hit_valid),
        .hit_id     (load_hit_ctx),
        .miss_v     (load_miss_valid),
        .miss_id    (load_miss_ctx),
        .alloc_v    (alloc_v),
        .alloc_id   (alloc_id),
        .rel_v      (rel_v),
        .rel_id     (rel_id),
        .eligible   (eligible),
        .waiting    (waiting)
    );

    miss_slot_pool #(
        .NUM_CTX   (NUM_CTX),
        .MISS_SLOTS(MISS_SLOTS),
        .MISS_STALL(MISS_STALL)
    ) u_pool (
        .clk     (clk),
        .rst     (rst),
        .miss_v  (load_miss_valid),
        .miss_id (load_miss_ctx),
        .waiting (waiting),
        .alloc_v (alloc_v),
        .alloc_id(alloc_id),
        .rel_v   (rel_v),
        .rel_id  (rel_id)
    );

    rr_ctx_picker #(.NUM_CTX(NUM_CTX)) u_pick (
        .eligible(eligible),
        .last_id (last_q),
        .pick_v  (fetch_valid),
        .pick_id (fetch_ctx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            last_q       <= CTX_W'(NUM_CTX - 1);
            bubble_count <= '0;
        end else if (fetch_valid) begin
            last_q       <= fetch_ctx;
        end else begin
            bubble_count <= bubble_count + BUBBLE_W'(1);
        end
    end

endmodule

// File: rtl/mt_fetch_sched_chk.sv
module mt_fetch_sched_chk #(
    parameter int unsigned NUM_CTX    = 200,
    parameter int unsigned MISS_SLOTS = 16,
    parameter int unsigned BUBBLE_W   = 32,
    parameter int unsigned CTX_W      = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                br_fetch_valid,
    input logic [CTX_W-1:0]    br_fetch_ctx,
    input logic                load_miss_valid,
    input logic [CTX_W-1:0]    load_miss_ctx,
    input logic                fetch_valid,
    input logic [CTX_W-1:0]    fetch_ctx,
    input logic [BUBBLE_W-1:0] bubble_count,
    input logic                alloc_v,
    input logic                rel_v
);

    logic        past_ok;
    int unsigned occ;

    always_ff @(posedge clk) begin
        if (rst) begin
            past_ok <= 1'b0;
            occ     <= 0;
        end else begin
            past_ok <= 1'b1;
            occ     <= occ + (alloc_v ? 1 : 0) - (rel_v ? 1 : 0);
        end
    end

    // R3
    br_lockout_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(br_fetch_valid)) |-> !(fetch_valid && fetch_ctx == $past(br_fetch_ctx)));

    // R4
    miss_lockout_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(load_miss_valid)) |-> !(fetch_valid && fetch_ctx == $past(load_miss_ctx)));

    // R5
    slot_cap_chk: assert property (@(posedge clk) disable iff (rst)
        occ <= MISS_SLOTS);

    // R6
    alloc_free_chk: assert property (@(posedge clk) disable iff (rst)
        alloc_v |-> (occ < MISS_SLOTS));

    // R8
    bubble_inc_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && !$past(fetch_valid)) |-> bubble_count == BUBBLE_W'($past(bubble_count) + 1'b1));

    // R8
    bubble_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (past_ok && $past(fetch_valid)) |-> $stable(bubble_count));

    // R9
    ctx_range_chk: assert property (@(posedge clk) disable iff (rst)
        fetch_valid |-> (32'(fetch_ctx) < NUM_CTX));

endmodule

bind mt_fetch_sched mt_fetch_sched_chk #(
    .NUM_CTX   (NUM_CTX),
    .MISS_SLOTS(MISS_SLOTS),
    .BUBBLE_W  (BUBBLE_W),
    .CTX_W     (CTX_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .br_fetch_valid (br_fetch_valid),
    .br_fetch_ctx   (br_fetch_ctx),
    .load_miss_valid(load_miss_valid),
    .load_miss_ctx  (load_miss_ctx),
    .fetch_valid    (fetch_valid),
    .fetch_ctx      (fetch_ctx),
    .bubble_count   (bubble_count),
    .alloc_v        (alloc_v),
    .rel_v          (rel_v)
);

// File: tb/sim_mt_fetch_sched.sv
`timescale 1ns/1ps
module sim_mt_fetch_sched;

    localparam int N     = 200;
    localparam int SLOTS = 16;
    localparam int STALL = 100;

    logic       clk = 1'b0;
    logic       rst;
    logic       br_fetch_valid, br_resolve_valid, load_hit_valid, load_miss_valid;
    logic [7:0] br_fetch_ctx, br_resolve_ctx, load_hit_ctx, load_miss_ctx;
    logic       fetch_valid;
    logic [7:0] fetch_ctx;
    logic [31:0] bubble_count;

    always #4 clk = ~clk;   // 125 MHz

    mt_fetch_sched u0 (
        .clk(clk), .rst(rst),
        .br_fetch_valid(br_fetch_valid), .br_fetch_ctx(br_fetch_ctx),
        .br_resolve_valid(br_resolve_valid), .br_resolve_ctx(br_resolve_ctx),
        .load_hit_valid(load_hit_valid), .load_hit_ctx(load_hit_ctx),
        .load_miss_valid(load_miss_valid), .load_miss_ctx(load_miss_ctx),
        .fetch_valid(fetch_valid), .fetch_ctx(fetch_ctx),
        .bubble_count(bubble_count)
    );

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    // Reference model: 0 run, 1 branch wait, 2 slot wait, 3 stall
    int m_state [N];
    bit m_busy  [SLOTS];
    int m_left  [SLOTS];
    int m_owner [SLOTS];
    int m_last;
    int m_bub;
    int m_waits;

    function automatic int exp_pick();
        for (int k = 1; k <= N; k++) begin
            int i = (m_last + k) % N;
            if (m_state[i] == 0) return i;
        end
        return -1;
    endfunction

    function automatic int find_state(int want, int start, int avoid);
        for (int k = 0; k < N; k++) begin
            int i = (start + k) % N;
            if (m_state[i] == want && i != avoid) return i;
        end
        return -1;
    endfunction

    task automatic check(string req, string what, int act, int expv);
        checks++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic model_step(bit bfv, int bfc, bit brv, int brc, bit mv, int mc);
        int free_s = -1;
        int wq     = -1;
        int pick   = exp_pick();
        int who    = -1;
        for (int s = SLOTS - 1; s >= 0; s--) if (!m_busy[s]) free_s = s;
        for (int c = N - 1; c >= 0; c--) if (m_state[c] == 2) wq = c;
        if (free_s >= 0) begin
            if (wq >= 0) who = wq;
            else if (mv) who = mc;
        end
        for (int s = 0; s < SLOTS; s++) begin
            if (m_busy[s]) begin
                if (m_left[s] == 1) begin
                    m_busy[s] = 0;
                    m_state[m_owner[s]] = 0;
                end else m_left[s]--;
            end
        end
        if (mv && who != mc) begin
            m_state[mc] = 2;
            m_waits++;
        end
        if (who >= 0) begin
            m_busy[free_s]  = 1;
            m_left[free_s]  = STALL;
            m_owner[free_s] = who;
            m_state[who]    = 3;
        end
        if (brv && m_state[brc] == 1) m_state[brc] = 0;
        if (bfv) m_state[bfc] = 1;
        if (pick < 0) m_bub++;
        else m_last = pick;
    endtask

    task automatic run_phase(string req, int cycles, int p_br, int p_res, int p_miss, int p_hit);
        for (int n = 0; n < cycles; n++) begin
            int  pick = exp_pick();
            bit  bfv = 0, brv = 0, mv = 0, hv = 0;
            int  bfc = 0, brc = 0, mc = 0, hc = 0;
            check(req, "fetch_valid", int'(fetch_valid), (pick >= 0) ? 1 : 0);
            if (pick >= 0) check(req, "fetch_ctx", int'(fetch_ctx), pick);
            check(req, "bubble_count", int'(bubble_count), m_bub);
            if (pick >= 0 && int'($urandom_range(99)) < p_br) begin
                bfv = 1; bfc = pick;
            end
            if (int'($urandom_range(99)) < p_miss) begin
                mc = find_state(0, int'($urandom_range(N - 1)), bfv ? bfc : -1);
                mv = (mc >= 0);
                if (!mv) mc = 0;
            end
            if (int'($urandom_range(99)) < p_res) begin
                brc = find_state(1, int'($urandom_range(N - 1)), -1);
                brv = (brc >= 0);
                if (!brv) brc = 0;
            end
            if (int'($urandom_range(99)) < p_hit) begin
                hv = 1; hc = int'($urandom_range(N - 1));
            end
            br_fetch_valid   = bfv; br_fetch_ctx   = 8'(bfc);
            br_resolve_valid = brv; br_resolve_ctx = 8'(brc);
            load_miss_valid  = mv;  load_miss_ctx  = 8'(mc);
            load_hit_valid   = hv;  load_hit_ctx   = 8'(hc);
            model_step(bfv, bfc, brv, brc, mv, mc);
            @(negedge clk);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = int'($urandom(32'h5EED_0042));
        rst = 1'b1;
        br_fetch_valid = 0; br_resolve_valid = 0; load_hit_valid = 0; load_miss_valid = 0;
        br_fetch_ctx = 0; br_resolve_ctx = 0; load_hit_ctx = 0; load_miss_ctx = 0;
        for (int i = 0; i < N; i++) m_state[i] = 0;
        for (int s = 0; s < SLOTS; s++) begin
            m_busy[s] = 0; m_left[s] = 0; m_owner[s] = 0;
        end
        m_last = N - 1; m_bub = 0; m_waits = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state and first pick
        check("R1", "reset fetch_valid", int'(fetch_valid), 1);
        check("R1", "reset fetch_ctx", int'(fetch_ctx), 0);
        check("R1", "reset bubble_count", int'(bubble_count), 0);
        run_phase("R1", 1, 0, 0, 0, 0);
        // R2, R9: plain round-robin wrapping past context 199
        run_phase("R2", 300, 0, 0, 0, 0);
        // R7: hits only, pick sequence unchanged
        run_phase("R7", 250, 0, 0, 0, 90);
        // R3: branch lockouts and resolves
        run_phase("R3", 400, 50, 30, 0, 20);
        // R4: sparse misses, exact 100-cycle stall
        run_phase("R4", 600, 20, 30, 5, 20);
        // R5: miss flood, slots saturate, contexts wait
        run_phase("R5", 900, 30, 5, 100, 10);
        // R6: drain waiting contexts through freed slots
        run_phase("R6", 700, 10, 50, 10, 10);
        // R8: every pick branches, nothing resolves, bubbles appear
        run_phase("R8", 400, 100, 0, 0, 0);
        run_phase("R3", 600, 0, 100, 0, 0);
        check("R8", "bubbles seen", (m_bub > 0) ? 1 : 0, 1);
        check("R5", "slot waits seen", (m_waits > 0) ? 1 : 0, 1);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule